// File: doc/BRIEF.md
# Dual-Bank Prioritized Interrupt Controller

This block collects up to 32 interrupt sources and presents them to a processor on two request lines: a normal request and a fast request. Each source first passes through a conditioning stage. A per-source polarity bit either keeps the input as it is or inverts it. A per-source latch bit picks between level-following behaviour and edge-captured, sticky behaviour. Both request lines see the same conditioned sources.

Each request line has its own bank of registers:
- a set of enables,
- a priority threshold,
- a masked status word,
- a current-source number chosen by priority,
- an acknowledge register that clears a captured source when it is read.

Every source also carries a 4-bit priority shared by both banks, where the value 0 is the most urgent.

Software runs a simple service loop. It reads a bank's masked status until that status reads zero. On each pass it reads the current-source number, or reads the acknowledge register, which returns the same number and releases a captured source. Configuration and status go through a single-cycle 32-bit register port. Read data is combinational from the address. Write and read side effects take place on the clock edge at which the strobe is high.

Top module: `prio_intc`

## Requirements
- R1: After reset, both banks have all enables at 0 and their thresholds at 0xF. All source priorities are 0, all latch-mode bits are 0 and all polarity bits are 1 (register 0x200 reads 0xFFFFFFFF).
- R2: Bank page p (0 = normal request, 1 = fast request) holds its enable controls at byte address p*0x100.
  - Writing a 1 to a bit at offset 0x08 enables that source.
  - Writing a 1 to a bit at offset 0x0C disables it.
  - A 0 bit in either write leaves the enable unchanged.
  - Reads at offset 0x08 and at offset 0x0C both return the enable mask.
- R3: The polarity register at 0x200 controls each conditioned source. A bit of 1 passes the input unchanged and a bit of 0 inverts it. Raw status at bank offset 0x04 shows every conditioned source after one clock of input registering, without enable or threshold applied.
- R4: The latch-mode register at 0x204 selects how each source behaves.
  - With bit 0, the source follows its conditioned input.
  - With bit 1, the source captures on a 0-to-1 change of the conditioned input. It stays pending after the input falls, until it is acknowledged. A capture edge wins over a clear in the same cycle.
- R5: Reading bank offset 0x28 returns the same number as offset 0x20. If that bank's masked status is nonzero, the read clears the captured state of the reported source only. A level-following source is unaffected.
- R6: Masked status at bank offset 0x00 is raw status AND the bank's enables AND priority eligibility. A source is eligible when its priority is at most the bank's threshold.
- R7: The current-source number at bank offset 0x20 is the masked source with the smallest priority value. Equal priorities go to the lowest source index. It reads 0 when masked status is zero.
- R8: The normal request output is high exactly when bank 0 masked status is nonzero. The fast request output is high exactly when bank 1 masked status is nonzero.
- R9: The two banks hold separate enables and thresholds. Writes to one bank leave the other bank's enables, threshold, masked status and output unchanged.
- R10: The following are writable and read back zero-extended:
  - the bank threshold at offset 0x2C (4 bits);
  - the source priority at 0x300 + 4*i (4 bits).

  Reads of any other address, including misaligned ones, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| bus_addr | input | ADDR_W | Register byte address |
| bus_rd | input | 1 | Read strobe; acknowledge side effect at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq_req_o | output | 1 | Normal interrupt request |
| fiq_req_o | output | 1 | Fast interrupt request |

## Verification
The assertions take four things for granted about the inputs:
- the source inputs are already synchronous to the clock;
- a register read and a write are never strobed in the same cycle;
- only one register is touched per cycle;
- an acknowledge read is therefore the only thing that clears a captured source in that cycle.

The bench keeps within these limits. It changes the inputs only at the falling edge and performs one bus operation or one source change per clock. It never raises both strobes together. Randomly chosen writes cover the enables, the thresholds, polarity, latch mode and priorities. Random reads and directed corner cases are checked against a register-level model kept in the bench. The corner cases are priority ties, threshold filtering, capture-then-acknowledge and bank isolation.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    // number of request banks and their page numbers
    localparam int BANK_N    = 2;
    localparam int BANK_IRQ  = 0;
    localparam int BANK_FIQ  = 1;

    // page numbers (address bits above the low byte)
    localparam int PAGE_CFG  = 2;
    localparam int PAGE_PRIO = 3;

    // offsets inside a bank page
    localparam logic [7:0] OFS_STAT  = 8'h00;
    localparam logic [7:0] OFS_RAW   = 8'h04;
    localparam logic [7:0] OFS_ENSET = 8'h08;
    localparam logic [7:0] OFS_ENCLR = 8'h0C;
    localparam logic [7:0] OFS_CUR   = 8'h20;
    localparam logic [7:0] OFS_ACK   = 8'h28;
    localparam logic [7:0] OFS_THR   = 8'h2C;

    // offsets inside the configuration page
    localparam logic [7:0] OFS_POL   = 8'h00;
    localparam logic [7:0] OFS_STK   = 8'h04;

endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] sticky_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] adj;
        logic [N-1:0] latch;
    } cond_t;

    cond_t        st_d, st_q;
    logic [N-1:0] adj_now;
    logic [N-1:0] rise;

    always_comb begin
        adj_now     = ~(src_i ^ pol_i);
        rise        = adj_now & ~st_q.adj;
        st_d.adj    = adj_now;
        st_d.latch  = sticky_i & ((st_q.latch & ~clr_i) | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.adj   <= '0;
            st_q.latch <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        assign pend_o[i] = sticky_i[i] ? st_q.latch[i] : st_q.adj[i];

        // R4: a captured source stays pending until cleared
        p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sticky_i[i] && st_q.latch[i] && !clr_i[i] |=> st_q.latch[i]);

        // R4: an active-going edge in latch mode is captured
        p_rise_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sticky_i[i] && adj_now[i] && !st_q.adj[i] |=> st_q.latch[i]);

        // R4: level-following mode keeps no captured state
        p_level_no_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !sticky_i[i] |=> !st_q.latch[i]);

        // R5: acknowledge without a new edge releases the capture
        p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] && !(adj_now[i] && !st_q.adj[i]) |=> !st_q.latch[i]);
    end

endmodule

// File: rtl/intc_bank_arb.sv
module intc_bank_arb #(
    parameter int N  = 32,
    parameter int PW = 4,
    parameter int IW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0]         en_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    input  logic [PW-1:0]        thr_i,
    output logic [N-1:0]         stat_o,
    output logic [IW-1:0]        cur_o,
    output logic                 req_o
);

    logic [N-1:0]  elig;
    logic [PW-1:0] best_p;
    logic [IW-1:0] best_i;
    logic          found;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            elig[i] = (prio_i[i] <= thr_i);
        end
        stat_o = pend_i & en_i & elig;

        best_p = '1;
        best_i = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (stat_o[i] && (!found || (prio_i[i] < best_p))) begin
                found  = 1'b1;
                best_p = prio_i[i];
                best_i = IW'(i);
            end
        end
    end

    assign cur_o = best_i;
    assign req_o = |stat_o;

    // R7: the reported source is one of the masked sources
    p_cur_in_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_o) |-> stat_o[cur_o]);

    // R7: nothing pending reports source 0
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_o) |-> (cur_o == '0));

    // R6: the reported source is enabled, pending and within threshold
    p_cur_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_o) |-> (en_i[cur_o] && pend_i[cur_o] && (prio_i[cur_o] <= thr_i)));

    // R8: request line and status agree
    p_req_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (stat_o != '0));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_req_o,
    output logic               fiq_req_o
);

    localparam int IDX_W  = $clog2(NUM_SRC);
    localparam int PAGE_W = ADDR_W - 8;
    localparam int NB     = BANK_N;

    typedef struct packed {
        logic [NB-1:0][NUM_SRC-1:0]     en;
        logic [NB-1:0][PRIO_W-1:0]      thr;
        logic [NUM_SRC-1:0]             pol;
        logic [NUM_SRC-1:0]             sticky;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    } regs_t;

    regs_t                      regs_d, regs_q;
    logic [PAGE_W-1:0]          page;
    logic [7:0]                 ofs;
    logic [5:0]                 pidx;
    logic                       pidx_ok;
    logic [NUM_SRC-1:0]         pend;
    logic [NUM_SRC-1:0]         clr;
    logic [NB-1:0][NUM_SRC-1:0] stat;
    logic [NB-1:0][IDX_W-1:0]   cur;
    logic [NB-1:0]              req;
    logic [DATA_W-1:0]          rd_mux;

    assign page    = bus_addr[ADDR_W-1:8];
    assign ofs     = bus_addr[7:0];
    assign pidx    = ofs[7:2];
    assign pidx_ok = (page == PAGE_W'(PAGE_PRIO)) && (ofs[1:0] == 2'b00)
                     && (int'(pidx) < NUM_SRC);

    // ---------------- next-state of the register file ----------------
    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            for (int b = 0; b < NB; b++) begin
                if (page == PAGE_W'(b)) begin
                    case (ofs)
                        OFS_ENSET: regs_d.en[b]  = regs_q.en[b] | bus_wdata[NUM_SRC-1:0];
                        OFS_ENCLR: regs_d.en[b]  = regs_q.en[b] & ~bus_wdata[NUM_SRC-1:0];
                        OFS_THR:   regs_d.thr[b] = bus_wdata[PRIO_W-1:0];
                        default: ;
                    endcase
                end
            end
            if (page == PAGE_W'(PAGE_CFG)) begin
                case (ofs)
                    OFS_POL: regs_d.pol    = bus_wdata[NUM_SRC-1:0];
                    OFS_STK: regs_d.sticky = bus_wdata[NUM_SRC-1:0];
                    default: ;
                endcase
            end
            if (pidx_ok) begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (pidx == 6'(i)) begin
                        regs_d.prio[i] = bus_wdata[PRIO_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.en     <= '0;
            regs_q.thr    <= '1;
            regs_q.pol    <= '1;
            regs_q.sticky <= '0;
            regs_q.prio   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // ---------------- acknowledge: clear the reported source ----------------
    always_comb begin
        clr = '0;
        if (bus_rd) begin
            for (int b = 0; b < NB; b++) begin
                if ((page == PAGE_W'(b)) && (ofs == OFS_ACK) && (|stat[b])) begin
                    clr[cur[b]] = 1'b1;
                end
            end
        end
    end

    // ---------------- read data ----------------
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NB; b++) begin
            if (page == PAGE_W'(b)) begin
                case (ofs)
                    OFS_STAT:           rd_mux = DATA_W'(stat[b]);
                    OFS_RAW:            rd_mux = DATA_W'(pend);
                    OFS_ENSET,
                    OFS_ENCLR:          rd_mux = DATA_W'(regs_q.en[b]);
                    OFS_CUR, OFS_ACK:   rd_mux = DATA_W'(cur[b]);
                    OFS_THR:            rd_mux = DATA_W'(regs_q.thr[b]);
                    default: ;
                endcase
            end
        end
        if (page == PAGE_W'(PAGE_CFG)) begin
            case (ofs)
                OFS_POL: rd_mux = DATA_W'(regs_q.pol);
                OFS_STK: rd_mux = DATA_W'(regs_q.sticky);
                default: ;
            endcase
        end
        if (pidx_ok) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (pidx == 6'(i)) begin
                    rd_mux = DATA_W'(regs_q.prio[i]);
                end
            end
        end
    end

    assign bus_rdata = rd_mux;

    // ---------------- datapath ----------------
    intc_src_cond #(.N(NUM_SRC)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .pol_i    (regs_q.pol),
        .sticky_i (regs_q.sticky),
        .clr_i    (clr),
        .pend_o   (pend)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        intc_bank_arb #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend),
            .en_i   (regs_q.en[b]),
            .prio_i (regs_q.prio),
            .thr_i  (regs_q.thr[b]),
            .stat_o (stat[b]),
            .cur_o  (cur[b]),
            .req_o  (req[b])
        );
    end

    assign irq_req_o = req[BANK_IRQ];
    assign fiq_req_o = req[BANK_FIQ];

    // R2: bits written to enable-set are enabled afterwards
    p_enset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (page == PAGE_W'(BANK_IRQ)) && (ofs == OFS_ENSET)
        |=> ((regs_q.en[BANK_IRQ] & $past(bus_wdata[NUM_SRC-1:0]))
             == $past(bus_wdata[NUM_SRC-1:0])));

    // R2: bits written to enable-clear are disabled afterwards
    p_enclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (page == PAGE_W'(BANK_FIQ)) && (ofs == OFS_ENCLR)
        |=> ((regs_q.en[BANK_FIQ] & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    // R9: writes to the normal bank leave the fast bank untouched
    p_bank_iso_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (page == PAGE_W'(BANK_IRQ))
        |=> ($stable(regs_q.en[BANK_FIQ]) && $stable(regs_q.thr[BANK_FIQ])));

    // R5: at most one source is released per acknowledge
    p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));

endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    import prio_intc_pkg::*;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src   = '0;
    logic [11:0] addr  = '0;
    logic        rd    = 1'b0;
    logic        wr    = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    always #10 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_rd(rd),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_req_o(irq), .fiq_req_o(fiq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    logic [31:0] m_en [2];
    logic [3:0]  m_thr [2];
    logic [31:0] m_pol, m_stk, m_adj, m_latch, m_src;
    logic [3:0]  m_prio [32];

    function automatic logic [31:0] raw();
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = m_stk[i] ? m_latch[i] : m_adj[i];
        return r;
    endfunction

    function automatic logic [31:0] masked(input int b);
        logic [31:0] r;
        r = raw() & m_en[b];
        for (int i = 0; i < 32; i++) if (m_prio[i] > m_thr[b]) r[i] = 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] cur(input int b);
        logic [31:0] s;
        int best;
        s = masked(b);
        best = -1;
        for (int i = 0; i < 32; i++)
            if (s[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
        return (best < 0) ? 32'd0 : 32'(best);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int pg;
        logic [7:0] o;
        pg = int'(a[11:8]);
        o  = a[7:0];
        if (pg < 2) begin
            case (o)
                8'h00: return masked(pg);
                8'h04: return raw();
                8'h08, 8'h0C: return m_en[pg];
                8'h20, 8'h28: return cur(pg);
                8'h2C: return 32'(m_thr[pg]);
                default: return '0;
            endcase
        end
        if (pg == 2) begin
            if (o == 8'h00) return m_pol;
            if (o == 8'h04) return m_stk;
            return '0;
        end
        if (pg == 3 && o[1:0] == 2'b00 && o[7:2] < 6'd32) return 32'(m_prio[o[6:2]]);
        return '0;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a[11:8] < 4'd2) begin
            case (a[7:0])
                8'h00: return "R6 status";
                8'h04: return "R3 raw";
                8'h08, 8'h0C: return "R2 enable";
                8'h20: return "R7 current";
                8'h28: return "R5 ack";
                default: return "R10 bank reg";
            endcase
        end
        return "R10 config";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // one modelled clock edge
    task automatic step(input logic [31:0] clr);
        logic [31:0] adjv, rise;
        adjv    = ~(m_src ^ m_pol);
        rise    = adjv & ~m_adj;
        m_latch = m_stk & ((m_latch & ~clr) | rise);
        m_adj   = adjv;
    endtask

    task automatic apply_write(input logic [11:0] a, input logic [31:0] d);
        int pg;
        pg = int'(a[11:8]);
        if (pg < 2) begin
            case (a[7:0])
                8'h08: m_en[pg] = m_en[pg] | d;
                8'h0C: m_en[pg] = m_en[pg] & ~d;
                8'h2C: m_thr[pg] = d[3:0];
                default: ;
            endcase
        end else if (pg == 2) begin
            if (a[7:0] == 8'h00) m_pol = d;
            if (a[7:0] == 8'h04) m_stk = d;
        end else if (pg == 3 && a[1:0] == 2'b00 && a[7:2] < 6'd32) begin
            m_prio[a[6:2]] = d[3:0];
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        step('0);
        apply_write(a, d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        logic [31:0] clr;
        int pg;
        addr = a; rd = 1'b1;
        #2;
        chk(tag, rdata, exp_read(a));
        chk("R8 irq pin", 32'(irq), 32'(|masked(0)));
        chk("R8 fiq pin", 32'(fiq), 32'(|masked(1)));
        clr = '0;
        pg  = int'(a[11:8]);
        if (pg < 2 && a[7:0] == 8'h28 && masked(pg) != '0) clr = 32'd1 << cur(pg);
        @(posedge clk);
        step(clr);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        src = v; m_src = v;
        @(posedge clk);
        step('0);
        @(negedge clk);
    endtask

    task automatic idle();
        @(posedge clk);
        step('0);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] rd_list [14];
        void'($urandom(32'd4711));
        m_en[0] = '0; m_en[1] = '0; m_thr[0] = 4'hF; m_thr[1] = 4'hF;
        m_pol = '1; m_stk = '0; m_adj = '0; m_latch = '0; m_src = '0;
        for (int i = 0; i < 32; i++) m_prio[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 irq pin low", 32'(irq), 32'd0);
        chk("R1 fiq pin low", 32'(fiq), 32'd0);
        bus_read(12'h008, "R1 irq enables");
        bus_read(12'h108, "R1 fiq enables");
        bus_read(12'h02C, "R1 irq threshold");
        bus_read(12'h12C, "R1 fiq threshold");
        bus_read(12'h200, "R1 polarity");
        bus_read(12'h204, "R1 latch mode");
        bus_read(12'h30C, "R1 priority");

        // R2: set and clear
        bus_write(12'h008, 32'h0000_00F0);
        bus_write(12'h00C, 32'h0000_0030);
        bus_read(12'h008, "R2 after set/clear");
        bus_read(12'h00C, "R2 clear address readback");
        bus_read(12'h108, "R9 other bank enables");
        bus_write(12'h00C, 32'hFFFF_FFFF);

        // R7: tie break and priority order
        bus_write(12'h008, (32'd1 << 4) | (32'd1 << 9));
        bus_write(12'h310, 32'd2);
        bus_write(12'h324, 32'd2);
        set_src((32'd1 << 4) | (32'd1 << 9));
        bus_read(12'h020, "R7 tie lowest index");
        bus_write(12'h310, 32'd5);
        bus_read(12'h020, "R7 lower value wins");
        bus_read(12'h000, "R6 status");

        // R6: threshold filters
        bus_write(12'h02C, 32'd1);
        bus_read(12'h000, "R6 threshold filter");
        bus_read(12'h020, "R7 none eligible");
        bus_write(12'h02C, 32'd5);
        bus_read(12'h020, "R6 threshold equal passes");
        bus_write(12'h02C, 32'hF);

        // R3: polarity inversion
        bus_write(12'h200, ~(32'd1 << 3));
        idle();
        bus_read(12'h004, "R3 inverted input");
        bus_write(12'h200, 32'hFFFF_FFFF);
        idle();
        bus_read(12'h004, "R3 restored polarity");

        // R4 and R5: capture then acknowledge
        bus_write(12'h00C, 32'hFFFF_FFFF);
        bus_write(12'h204, 32'd1 << 7);
        bus_write(12'h008, 32'd1 << 7);
        set_src(src | (32'd1 << 7));
        set_src(src & ~(32'd1 << 7));
        bus_read(12'h004, "R4 captured after input fell");
        bus_read(12'h000, "R4 captured in status");
        bus_read(12'h028, "R5 ack returns source");
        bus_read(12'h004, "R5 cleared after ack");
        bus_read(12'h028, "R5 ack with nothing pending");
        bus_write(12'h008, 32'd1 << 4);
        bus_read(12'h028, "R5 ack on level source");
        bus_read(12'h004, "R5 level source unaffected");

        // R9: fast bank independent
        bus_write(12'h108, 32'd1 << 20);
        set_src(src | (32'd1 << 20));
        bus_read(12'h100, "R9 fast bank status");
        bus_read(12'h000, "R9 normal bank unaffected");
        bus_write(12'h12C, 32'd0);
        bus_read(12'h100, "R9 fast threshold");
        bus_read(12'h02C, "R9 normal threshold kept");

        // R10: widths and unmapped
        bus_write(12'h02C, 32'hFFFF_FFF3);
        bus_read(12'h02C, "R10 threshold width");
        bus_write(12'h37C, 32'hFFFF_FFFA);
        bus_read(12'h37C, "R10 priority width");
        bus_read(12'h010, "R10 unmapped bank offset");
        bus_read(12'h400, "R10 unmapped page");
        bus_read(12'h382, "R10 misaligned");
        bus_write(12'h02C, 32'hF);

        // constrained random phase
        rd_list = '{12'h000, 12'h004, 12'h008, 12'h020, 12'h028, 12'h02C,
                    12'h100, 12'h104, 12'h10C, 12'h120, 12'h128, 12'h12C,
                    12'h200, 12'h204};
        for (int n = 0; n < 800; n++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 2) begin
                if ($urandom % 4 == 0) set_src($urandom);
                else set_src(src ^ (32'd1 << ($urandom % 32)));
            end else if (op < 5) begin
                int kind, b;
                kind = int'($urandom % 6);
                b    = int'($urandom % 2);
                case (kind)
                    0: bus_write(12'(b * 256 + 8),  $urandom & $urandom);
                    1: bus_write(12'(b * 256 + 12), $urandom & $urandom & $urandom);
                    2: bus_write(12'(b * 256 + 44), 32'(($urandom % 4 == 0) ? $urandom % 16 : 15));
                    3: bus_write(12'h200, ~($urandom & $urandom & $urandom));
                    4: bus_write(12'h204, $urandom);
                    default: bus_write(12'(768 + 4 * ($urandom % 32)), $urandom % 4);
                endcase
            end else begin
                logic [11:0] a;
                if ($urandom % 6 == 0) a = 12'(768 + 4 * ($urandom % 32));
                else a = rd_list[$urandom % 14];
                bus_read(a, tag_of(a));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule